// File: doc/BRIEF.md
# Burst-of-four DDR SRAM sequencer

This block is the device side of a common-I/O, double-data-rate SRAM that moves four data beats for every accepted command. It decodes the load strobe and the read/write select, locks the control pins out while a burst is under way, steps a beat counter through the burst addresses, and reads or writes a small internal word array one word per beat. Read data and the output-enable that stands in for the tri-state bus come from registers.

One clock runs at the beat rate. An internal phase bit splits its rising edges into true-clock edges and complementary-clock edges, which alternate, and it is visible on `true_edge`. Control inputs count only on true-clock edges. Once a command is taken, the following true-clock edge is skipped, so new commands arrive at most every fourth beat. Commands issued at that rate produce an unbroken data stream.

The data paths are streams with fixed timing and no back-pressure. `rd_valid` marks each read beat and the consumer must take every beat it marks. `wr_take` acts as the ready for write data. The host must hold the matching write beat on `wr_data` whenever `wr_take` is high, and that word is stored at the next clock edge.

Top module: `b4_sram_seq`

## Requirements
- R1: Every accepted command moves exactly four data beats on four consecutive clock edges.
- R2: `true_edge` is 1 in the first cycle after reset and toggles every cycle. `load_n`, `rd_wr_n` and `cmd_addr` have an effect only at edges where `true_edge` was 1. Edges with `true_edge` 0 ignore them.
- R3: A command is accepted at a true-clock edge when `load_n` is 0 and the control pins are not locked. `rd_wr_n` = 1 selects a read and 0 selects a write. The true-clock edge right after an accepted command ignores all control inputs.
- R4: `load_n` = 1 at an evaluated true-clock edge is a deselect and adds no beats. The next true-clock edge is evaluated again.
- R5: Take the command edge as edge n. A read drives beats on edges n+2 through n+5. `rd_valid` is 1 in the cycle after each of those edges.
- R6: Take the command edge as edge n. A write captures `wr_data` at edges n+2 through n+5. `wr_take` is 1 in the cycle just before each capturing edge and 0 otherwise.
- R7: Beat b (0 to 3) of a burst uses address {`cmd_addr`[ADDR_W-1:2], b}. The two low command address bits are ignored.
- R8: `out_en` equals `rd_valid` at all times. Both are 0 outside read beats, including during write beats and after a deselect once the last burst has finished.
- R9: Commands accepted every four edges, in any order of reads and writes, give data on every edge with no gap.
- R10: Reset, including a reset in the middle of a burst, clears `rd_valid`, `out_en` and `wr_take` and cancels any outstanding burst. The first true-clock edge after reset evaluates the control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Load strobe, active low; high means deselect |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Burst base word address |
| wr_data | input | DATA_W | Write beat data |
| true_edge | output | 1 | Next rising edge is a true-clock edge |
| wr_take | output | 1 | Write data on `wr_data` is stored at the next edge |
| rd_data | output | DATA_W | Read beat data |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| out_en | output | 1 | Output drivers enabled; 0 models high impedance |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 16. This gives a 64-word array of sixteen burst blocks, so base addresses with nonzero low bits can be aimed at a block that was just written and the masking of those bits shows up in the data read back. The 16-bit words carry a distinct seed per write burst plus the beat index, so a wrong beat order, a skipped beat or data from the wrong block produces a different word. The same configuration covers writes landing right behind reads, requests on locked edges and on complementary edges, and a reset part way through a read.

// File: rtl/b4_sram_pkg.sv
package b4_sram_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;
endpackage

// File: rtl/b4_cmd_ctrl.sv
module b4_cmd_ctrl
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              true_edge,
  output logic              cmd_acc,
  output logic              pend_v,
  output op_e               pend_op,
  output logic [ADDR_W-1:0] pend_addr
);
  logic phase_q;
  logic lock_q;

  assign true_edge = phase_q;
  assign cmd_acc   = phase_q & ~lock_q & ~load_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b1;
      lock_q    <= 1'b0;
      pend_v    <= 1'b0;
      pend_op   <= OP_READ;
      pend_addr <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        lock_q <= cmd_acc;
        pend_v <= cmd_acc;
        if (cmd_acc) begin
          pend_op   <= op_e'(rd_wr_n);
          pend_addr <= cmd_addr;
        end
      end
    end
  end
endmodule

// File: rtl/b4_burst_seq.sv
module b4_burst_seq
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              true_edge,
  input  logic              pend_v,
  input  op_e               pend_op,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic              beat_v,
  output op_e               beat_op,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              run_q;
  logic [BEAT_W-1:0] cnt_q;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic              start;
  logic [BEAT_W-1:0] beat_idx;
  logic [ADDR_W-1:0] base_sel;

  assign start    = true_edge & pend_v;
  assign beat_v   = start | run_q;
  assign beat_idx = start ? '0 : cnt_q;
  assign base_sel = start ? pend_addr : base_q;
  assign beat_op  = start ? pend_op : op_q;
  assign beat_addr = {base_sel[ADDR_W-1:BEAT_W], beat_idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      base_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      cnt_q  <= BEAT_W'(1);
      op_q   <= pend_op;
      base_q <= pend_addr;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_BEAT) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/b4_store.sv
module b4_store
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_v,
  input  op_e               beat_op,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              out_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_beat;
  logic              wr_beat;

  assign rd_beat = beat_v & (beat_op == OP_READ);
  assign wr_beat = beat_v & (beat_op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (wr_beat) mem[beat_addr] <= wr_data;
    if (rd_beat) rd_data <= mem[beat_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      out_en   <= 1'b0;
    end else begin
      rd_valid <= rd_beat;
      out_en   <= rd_beat;
    end
  end
endmodule

// File: rtl/b4_sram_seq.sv
module b4_sram_seq
  import b4_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              true_edge,
  output logic              wr_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              out_en
);
  logic              cmd_acc;
  logic              pend_v;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic              beat_v;
  op_e               beat_op;
  logic [ADDR_W-1:0] beat_addr;

  b4_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr_n(rd_wr_n),
    .cmd_addr(cmd_addr), .true_edge(true_edge), .cmd_acc(cmd_acc),
    .pend_v(pend_v), .pend_op(pend_op), .pend_addr(pend_addr)
  );

  b4_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .true_edge(true_edge), .pend_v(pend_v),
    .pend_op(pend_op), .pend_addr(pend_addr), .beat_v(beat_v),
    .beat_op(beat_op), .beat_addr(beat_addr)
  );

  b4_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .beat_v(beat_v), .beat_op(beat_op),
    .beat_addr(beat_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .out_en(out_en)
  );

  assign wr_take = beat_v & (beat_op == OP_WRITE);
endmodule

// File: rtl/b4_sram_chk.sv
module b4_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_wr_n,
  input logic true_edge,
  input logic cmd_acc,
  input logic rd_valid,
  input logic out_en,
  input logic wr_take
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (true_edge != $past(true_edge))); // R2

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |-> ##2 !cmd_acc); // R3

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && rd_wr_n) |-> ##3 rd_valid); // R5

  AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && !rd_wr_n) |-> ##2 wr_take); // R6

  AST_RD_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_valid ##1 rd_valid ##1 rd_valid ##1 rd_valid); // R1

  AST_OE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_en == rd_valid); // R8

  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !out_en); // R8
endmodule

bind b4_sram_seq b4_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_wr_n(rd_wr_n), .true_edge(true_edge),
  .cmd_acc(cmd_acc), .rd_valid(rd_valid), .out_en(out_en), .wr_take(wr_take)
);

// File: tb/b4_sram_seq_tb.sv
module b4_sram_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N_SLOT = 40;
  localparam int N_CMD = 11;

  // kind: 0 none, 1 read, 2 write, 3 request on a locked edge (seed[0]=1 read)
  typedef struct packed {
    logic [1:0]    kind;
    logic [5:0]    slot;
    logic [AW-1:0] addr;
    logic [DW-1:0] seed;
  } cmd_t;

  localparam cmd_t CMDS [N_CMD] = '{
    '{2'd2, 6'd0,  6'h08, 16'hA000},
    '{2'd3, 6'd2,  6'h3F, 16'h0001},
    '{2'd2, 6'd4,  6'h13, 16'hB100},
    '{2'd3, 6'd6,  6'h00, 16'h0000},
    '{2'd1, 6'd8,  6'h08, 16'h0000},
    '{2'd1, 6'd12, 6'h11, 16'h0000},
    '{2'd2, 6'd16, 6'h20, 16'hC200},
    '{2'd1, 6'd22, 6'h22, 16'h0000},
    '{2'd3, 6'd24, 6'h08, 16'h0000},
    '{2'd1, 6'd26, 6'h0A, 16'h0000},
    '{2'd1, 6'd30, 6'h13, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_n = 1'b1;
  logic          rd_wr_n = 1'b1;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          true_edge;
  logic          wr_take;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          out_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic          s_ld_n [N_SLOT];
  logic          s_rw   [N_SLOT];
  logic [AW-1:0] s_addr [N_SLOT];
  logic [DW-1:0] s_wd   [N_SLOT];
  logic          e_rv   [N_SLOT];
  logic          e_wt   [N_SLOT];
  logic [DW-1:0] e_rd   [N_SLOT];
  logic [DW-1:0] shadow [1<<AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  b4_sram_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr_n(rd_wr_n),
    .cmd_addr(cmd_addr), .wr_data(wr_data), .true_edge(true_edge),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .out_en(out_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // build the schedule from the command table
    for (int i = 0; i < N_SLOT; i++) begin
      s_ld_n[i] = 1'b1; s_rw[i] = 1'b1; s_addr[i] = '0; s_wd[i] = '0;
      e_rv[i] = 1'b0; e_wt[i] = 1'b0; e_rd[i] = '0;
    end
    for (int c = 0; c < N_CMD; c++) begin
      cmd_t m;
      int s;
      logic [AW-1:0] base;
      m = CMDS[c];
      s = int'(m.slot);
      base = {m.addr[AW-1:2], 2'b00};
      if (m.kind != 2'd0) begin
        s_ld_n[s] = 1'b0;
        s_addr[s] = m.addr;
        s_rw[s] = (m.kind == 2'd1) || (m.kind == 2'd3 && m.seed[0]);
      end
      for (int b = 0; b < 4; b++) begin
        if (m.kind == 2'd2) begin
          s_wd[s+2+b] = m.seed + DW'(b);
          shadow[base + AW'(b)] = m.seed + DW'(b);
          e_wt[s+2+b] = 1'b1;
        end else if (m.kind == 2'd1) begin
          e_rv[s+2+b] = 1'b1;
          e_rd[s+2+b] = shadow[base + AW'(b)];
        end
      end
    end

    // reset state (R10)
    repeat (3) @(negedge clk);
    chk("R10 rd_valid", DW'(rd_valid), '0);
    chk("R10 out_en", DW'(out_en), '0);
    chk("R10 wr_take", DW'(wr_take), '0);
    chk("R2 true_edge after reset", DW'(true_edge), DW'(1));
    rst_n = 1'b1;

    // table walk: slot 0 is the first edge after reset, a true-clock edge
    for (int i = 0; i < N_SLOT; i++) begin
      chk("R2 phase", DW'(true_edge), DW'((i % 2) == 0));
      chk("R6 R3 wr_take", DW'(wr_take), DW'(e_wt[i]));
      load_n = s_ld_n[i]; rd_wr_n = s_rw[i]; cmd_addr = s_addr[i]; wr_data = s_wd[i];
      @(posedge clk);
      @(negedge clk);
      chk("R5 R9 rd_valid", DW'(rd_valid), DW'(e_rv[i]));
      chk("R8 out_en", DW'(out_en), DW'(e_rv[i]));
      if (e_rv[i]) chk("R7 R1 rd_data", rd_data, e_rd[i]);
    end
    load_n = 1'b1;

    // request on a complementary edge is ignored (R2)
    if (true_edge) @(negedge clk);
    load_n = 1'b0; rd_wr_n = 1'b1; cmd_addr = 6'h08;
    @(negedge clk);
    load_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2 C-edge ignored rd_valid", DW'(rd_valid), '0);
      chk("R2 C-edge ignored wr_take", DW'(wr_take), '0);
    end

    // reset in the middle of a read burst (R10), then read on the first edge
    if (!true_edge) @(negedge clk);
    load_n = 1'b0; rd_wr_n = 1'b1; cmd_addr = 6'h20;
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 first beat before reset", DW'(rd_valid), DW'(1));
    rst_n = 1'b0;
    #1;
    chk("R10 mid-burst rd_valid", DW'(rd_valid), '0);
    chk("R10 mid-burst out_en", DW'(out_en), '0);
    @(negedge clk);
    chk("R10 true_edge in reset", DW'(true_edge), DW'(1));
    load_n = 1'b0; rd_wr_n = 1'b1; cmd_addr = 6'h10;
    rst_n = 1'b1;
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    chk("R10 burst cancelled", DW'(rd_valid), '0);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      chk("R1 R10 beat valid", DW'(rd_valid), DW'(1));
      chk("R7 R10 beat data", rd_data, 16'hB100 + DW'(b));
    end
    @(negedge clk);
    chk("R1 R4 R8 burst ends", DW'(out_en), '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule